// File: doc/BRIEF.md
# Double-Buffered Memory-to-Peripheral Transfer Stream

This block is one transfer channel that copies 32-bit words from memory into a peripheral data register. Each request pulse from the peripheral moves one word. The channel holds two memory base addresses and a buffer-select bit that picks which of the two is read. A remaining-word counter decides when a pass over the current buffer ends. In ping-pong mode the channel swaps to the other buffer at the end of every pass and reloads the count, so software can refill one buffer while the other streams out.

Software programs the channel through a small word-addressed register port. The memory side is a plain read port that always grants and returns data one cycle after the read strobe. The channel reports pass completion and half-pass progress through two sticky flags that software clears by writing ones. Buffer select, ping-pong enable, base addresses and count are frozen while the channel runs. The buffer-select bit therefore changes only when a pass runs out, or by a software write while the channel is stopped.

Top module: `dbuf_dma_stream`

## Requirements
- R1: After reset, the control, count and status registers read 0 and no memory read or peripheral write occurs.
- R2: While running with no word in flight, a high `req_i` issues one memory read (`mem_re_o`), and in the following cycle `per_we_o` is high with `per_wdata_o` equal to the returned memory word.
- R3: The read address is the selected base plus 4 times the number of words already moved in the current pass (base 0 at register offset 2 when buffer select is 0, base 1 at offset 3 when it is 1).
- R4: In ping-pong mode (control bit 1 set), the word that brings the count to zero toggles buffer select (control bit 19), reloads the count and restarts at the other base, and it sets the transfer-complete flag (status bit 0).
- R5: With ping-pong mode clear, the count reaching zero clears the running bit (control bit 0), leaves buffer select unchanged and sets the transfer-complete flag.
- R6: Writing control bit 0 low stops the channel without toggling buffer select. The running bit still reads 1 in the cycle after the write and reads 0 one cycle later, or one cycle after an in-flight word finishes. No word moves once it reads 0.
- R7: While running, writes to buffer select, ping-pong enable, both bases and the count (offset 1) are ignored.
- R8: A buffer-select value written while stopped is the one used when the channel is next enabled.
- R9: Setting control bit 0 while stopped, with a nonzero count, restarts at word 0 of the selected base with the written count.
- R10: The half-transfer flag (status bit 1, status at offset 4) sets when the count after a word equals the reload value divided by two, rounded down.
- R11: Writing a 1 to a bit of the flag-clear register (offset 5) clears that flag only, and a bit written 0 leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 3 | Register word offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| req_i | input | 1 | Peripheral word request |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_rdata_i | input | 32 | Memory data, one cycle after the strobe |
| per_we_o | output | 1 | Peripheral data write strobe |
| per_wdata_o | output | 32 | Peripheral write data |
| tc_o | output | 1 | Transfer-complete flag |
| ht_o | output | 1 | Half-transfer flag |

## Verification
The assertions assume that memory answers every read strobe with valid data in the next cycle and that only one register write arrives per cycle. They also assume that `req_i` is sampled as a level, so a request held high while a word is in flight is taken again once the channel is idle. The stimulus holds each request for exactly one cycle and spaces requests so each word finishes before the next. The bench memory model returns data one cycle after the strobe, and every register access is a single-cycle strobe driven on the falling edge.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
  localparam int unsigned RW = 32;
  localparam int unsigned OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_CTRL  = 3'd0,
    OFS_CNT   = 3'd1,
    OFS_BASE0 = 3'd2,
    OFS_BASE1 = 3'd3,
    OFS_STAT  = 3'd4,
    OFS_CLR   = 3'd5
  } reg_ofs_e;

  localparam int unsigned BIT_RUN = 0;
  localparam int unsigned BIT_PP  = 1;
  localparam int unsigned BIT_SEL = 19;
  localparam int unsigned BIT_TC  = 0;
  localparam int unsigned BIT_HT  = 1;
endpackage

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
  import dma_stream_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic          cnt_we_i,
  input  logic [RW-1:0] wdata_i,
  input  logic [CW-1:0] reload_i,
  input  logic          pp_en_i,
  input  logic [AW-1:0] base0_i,
  input  logic [AW-1:0] base1_i,
  input  logic          req_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          per_we_o,
  output logic          run_o,
  output logic          sel_o,
  output logic [CW-1:0] rem_o,
  output logic          tc_evt_o,
  output logic          ht_evt_o,
  output logic          wrap_o
);
  localparam int unsigned PAD = AW - CW - 2;

  logic          run_q, stop_q, busy_q, sel_q;
  logic [CW-1:0] rem_q, idx_q, rem_nxt;
  logic          start, stop_req, fire, last;

  assign start    = ctrl_we_i & wdata_i[BIT_RUN] & ~run_q & (reload_i != '0);
  assign stop_req = ctrl_we_i & ~wdata_i[BIT_RUN] & run_q;
  assign fire     = run_q & ~stop_q & ~busy_q & req_i;
  assign rem_nxt  = rem_q - 1'b1;
  assign last     = busy_q & (rem_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      rem_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= fire;
      if (start) begin
        run_q <= 1'b1;
        stop_q <= 1'b0;
        rem_q <= reload_i;
        idx_q <= '0;
        sel_q <= wdata_i[BIT_SEL];
      end else if (!run_q) begin
        if (ctrl_we_i) sel_q <= wdata_i[BIT_SEL];
        if (cnt_we_i) rem_q <= wdata_i[CW-1:0];
      end
      if (stop_req) stop_q <= 1'b1;
      if (busy_q) begin
        if (last) begin
          if (pp_en_i) begin
            rem_q <= reload_i;
            idx_q <= '0;
            sel_q <= ~sel_q;
          end else begin
            rem_q <= '0;
            run_q <= 1'b0;
            stop_q <= 1'b0;
          end
        end else begin
          rem_q <= rem_nxt;
          idx_q <= idx_q + 1'b1;
        end
      end else if (stop_q) begin
        run_q  <= 1'b0;
        stop_q <= 1'b0;
      end
    end
  end

  assign mem_re_o   = fire;
  assign mem_addr_o = (sel_q ? base1_i : base0_i) + {{PAD{1'b0}}, idx_q, 2'b00};
  assign per_we_o   = busy_q;
  assign run_o      = run_q;
  assign sel_o      = sel_q;
  assign rem_o      = rem_q;
  assign tc_evt_o   = last;
  assign ht_evt_o   = busy_q & (rem_nxt == (reload_i >> 1));
  assign wrap_o     = last & pp_en_i;
endmodule

// File: rtl/dma_stream_regs.sv
module dma_stream_regs
  import dma_stream_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OFS_W-1:0] addr_i,
  input  logic             we_i,
  input  logic [RW-1:0]    wdata_i,
  output logic [RW-1:0]    rdata_o,
  input  logic             run_i,
  input  logic             sel_i,
  input  logic [CW-1:0]    rem_i,
  input  logic             tc_evt_i,
  input  logic             ht_evt_i,
  output logic             ctrl_we_o,
  output logic             cnt_we_o,
  output logic [CW-1:0]    reload_o,
  output logic             pp_en_o,
  output logic [AW-1:0]    base0_o,
  output logic [AW-1:0]    base1_o,
  output logic             tc_o,
  output logic             ht_o
);
  logic [AW-1:0] base_q [2];
  logic [CW-1:0] reload_q;
  logic          pp_q, tc_q, ht_q, clr_we;

  assign ctrl_we_o = we_i & (addr_i == OFS_CTRL);
  assign cnt_we_o  = we_i & (addr_i == OFS_CNT);
  assign clr_we    = we_i & (addr_i == OFS_CLR);

  for (genvar b = 0; b < 2; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q[b] <= '0;
      else if (we_i && !run_i && addr_i == OFS_W'(OFS_BASE0 + b)) base_q[b] <= wdata_i[AW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      pp_q     <= 1'b0;
      tc_q     <= 1'b0;
      ht_q     <= 1'b0;
    end else begin
      if (!run_i && cnt_we_o) reload_q <= wdata_i[CW-1:0];
      if (!run_i && ctrl_we_o) pp_q <= wdata_i[BIT_PP];
      // set has priority over clear
      if (tc_evt_i) tc_q <= 1'b1;
      else if (clr_we && wdata_i[BIT_TC]) tc_q <= 1'b0;
      if (ht_evt_i) ht_q <= 1'b1;
      else if (clr_we && wdata_i[BIT_HT]) ht_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[BIT_RUN] = run_i;
        rdata_o[BIT_PP]  = pp_q;
        rdata_o[BIT_SEL] = sel_i;
      end
      OFS_CNT:   rdata_o[CW-1:0] = rem_i;
      OFS_BASE0: rdata_o[AW-1:0] = base_q[0];
      OFS_BASE1: rdata_o[AW-1:0] = base_q[1];
      OFS_STAT: begin
        rdata_o[BIT_TC] = tc_q;
        rdata_o[BIT_HT] = ht_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign pp_en_o  = pp_q;
  assign base0_o  = base_q[0];
  assign base1_o  = base_q[1];
  assign tc_o     = tc_q;
  assign ht_o     = ht_q;
endmodule

// File: rtl/dbuf_dma_stream.sv
module dbuf_dma_stream
  import dma_stream_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OFS_W-1:0] reg_addr_i,
  input  logic             reg_we_i,
  input  logic [RW-1:0]    reg_wdata_i,
  output logic [RW-1:0]    reg_rdata_o,
  input  logic             req_i,
  output logic             mem_re_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [RW-1:0]    mem_rdata_i,
  output logic             per_we_o,
  output logic [RW-1:0]    per_wdata_o,
  output logic             tc_o,
  output logic             ht_o
);
  logic          ctrl_we, cnt_we, pp_en, run, sel, tc_evt, ht_evt, wrap;
  logic [CW-1:0] reload, rem;
  logic [AW-1:0] base0, base1;

  dma_stream_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .run_i(run), .sel_i(sel), .rem_i(rem), .tc_evt_i(tc_evt), .ht_evt_i(ht_evt),
    .ctrl_we_o(ctrl_we), .cnt_we_o(cnt_we), .reload_o(reload), .pp_en_o(pp_en),
    .base0_o(base0), .base1_o(base1), .tc_o, .ht_o
  );

  dma_stream_engine #(.AW(AW), .CW(CW)) u_eng (
    .clk_i, .rst_ni,
    .ctrl_we_i(ctrl_we), .cnt_we_i(cnt_we), .wdata_i(reg_wdata_i),
    .reload_i(reload), .pp_en_i(pp_en), .base0_i(base0), .base1_i(base1),
    .req_i, .mem_re_o, .mem_addr_o, .per_we_o,
    .run_o(run), .sel_o(sel), .rem_o(rem), .tc_evt_o(tc_evt), .ht_evt_o(ht_evt), .wrap_o(wrap)
  );

  assign per_wdata_o = mem_rdata_i;
endmodule

// File: rtl/dbuf_dma_stream_chk.sv
module dbuf_dma_stream_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          mem_re_o,
  input logic          per_we_o,
  input logic          run,
  input logic          sel,
  input logic          wrap,
  input logic          tc_o,
  input logic [AW-1:0] base0,
  input logic [AW-1:0] base1
);
  p_read_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (req_i && run));
  p_write_follows_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> per_we_o);
  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_we_o |-> !mem_re_o);
  p_sel_moves_on_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && sel != $past(sel)) |-> $past(wrap));
  p_tc_after_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> tc_o);
  p_idle_no_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !mem_re_o);
  p_base0_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> base0 == $past(base0));
  p_base1_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run)) |-> base1 == $past(base1));
endmodule

bind dbuf_dma_stream dbuf_dma_stream_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mem_re_o(mem_re_o), .per_we_o(per_we_o),
  .run(run), .sel(sel), .wrap(wrap), .tc_o(tc_o), .base0(base0), .base1(base1)
);

// File: tb/dbuf_dma_stream_bench.sv
module dbuf_dma_stream_bench;
  localparam logic [31:0] KEY = 32'h5A00_00C3;
  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_B0 = 3'd2, A_B1 = 3'd3,
                         A_STAT = 3'd4, A_CLR = 3'd5;
  localparam logic [31:0] RUN = 32'h1, PP = 32'h2, SEL = 32'h0008_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_we = 1'b0, req = 1'b0;
  logic [31:0] reg_wdata = '0, rdata, mem_addr, mem_rdata = '0, per_wdata;
  logic mem_re, per_we, tc, ht;

  int checks = 0, fails = 0, nlog = 0, cyc = 0;
  logic [31:0] wlog [0:63];
  bit done = 0;

  always #2 clk = ~clk;

  dbuf_dma_stream u_dbuf_dma_stream (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .req_i(req), .mem_re_o(mem_re),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .per_we_o(per_we),
    .per_wdata_o(per_wdata), .tc_o(tc), .ht_o(ht)
  );

  always @(posedge clk) if (mem_re) mem_rdata <= mem_addr ^ KEY;

  always @(negedge clk) if (per_we && nlog < 64) begin
    wlog[nlog] = per_wdata;
    nlog++;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = rdata;
  endtask

  task automatic word();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_word(string tag, int i, logic [31:0] addr);
    chk(tag, (i < nlog) ? wlog[i] : 32'hxxxx_xxxx, addr ^ KEY);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_CNT, d);  chk("R1 count", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    chk("R1 no writes", nlog, 0);
  endtask

  task automatic t_pingpong();
    logic [31:0] d;
    wr(A_B0, 32'h1000); wr(A_B1, 32'h2000); wr(A_CNT, 4);
    wr(A_CTRL, RUN | PP);
    word(); word();
    chk_word("R2 first word", 0, 32'h1000);
    chk_word("R3 second word", 1, 32'h1004);
    rd(A_STAT, d); chk("R10 half flag only", d, 2);
    rd(A_CNT, d);  chk("R3 remaining", d, 2);
    word(); word();
    chk_word("R3 fourth word", 3, 32'h100C);
    rd(A_CTRL, d); chk("R4 select toggled", d, RUN | PP | SEL);
    rd(A_CNT, d);  chk("R4 count reloaded", d, 4);
    rd(A_STAT, d); chk("R4 tc set", d, 3);
    word(); word();
    chk_word("R4 other base", 4, 32'h2000);
    chk_word("R3 other base next", 5, 32'h2004);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); chk("R11 clear tc only", d, 2);
    wr(A_CLR, 32'h2);
    rd(A_STAT, d); chk("R11 clear ht", d, 0);
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    wr(A_B0, 32'hDEAD_0000); wr(A_CNT, 9); wr(A_CTRL, RUN);
    rd(A_CTRL, d); chk("R7 ctrl kept", d, RUN | PP | SEL);
    rd(A_B0, d);   chk("R7 base kept", d, 32'h1000);
    rd(A_CNT, d);  chk("R7 count kept", d, 2);
    word();
    chk_word("R7 stream continues", 6, 32'h2008);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    int n;
    wr(A_CTRL, PP | SEL);
    rd(A_CTRL, d); chk("R6 run still set", d[0], 1);
    @(negedge clk);
    rd(A_CTRL, d); chk("R6 stopped no toggle", d, PP | SEL);
    n = nlog;
    word();
    chk("R6 no word when stopped", nlog, n);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    wr(A_CNT, 3);
    wr(A_CTRL, PP);
    rd(A_CTRL, d); chk("R8 select written", d, PP);
    wr(A_CTRL, RUN | PP);
    rd(A_CNT, d);  chk("R9 fresh count", d, 3);
    word();
    chk_word("R8 R9 restart base0", 7, 32'h1000);
  endtask

  task automatic t_inflight();
    logic [31:0] d;
    @(negedge clk);
    req = 1'b1; reg_addr = A_CTRL; reg_wdata = PP; reg_we = 1'b1;
    @(negedge clk);
    req = 1'b0; reg_we = 1'b0;
    @(negedge clk);
    rd(A_CTRL, d); chk("R6 run during in-flight", d[0], 1);
    @(negedge clk);
    rd(A_CTRL, d); chk("R6 stopped after word", d, PP);
    chk_word("R6 in-flight word done", 8, 32'h1004);
    rd(A_CNT, d);  chk("R6 remaining kept", d, 1);
  endtask

  task automatic t_single();
    logic [31:0] d;
    int n;
    wr(A_CNT, 2);
    wr(A_CTRL, RUN | SEL);
    word();
    rd(A_STAT, d); chk("R10 half at 1 of 2", d, 2);
    word();
    chk_word("R5 single second word", 10, 32'h2004);
    rd(A_CTRL, d); chk("R5 stopped, select kept", d, SEL);
    rd(A_STAT, d); chk("R5 tc set", d, 3);
    n = nlog;
    word();
    chk("R5 no more words", nlog, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pingpong();
    t_clear();
    t_frozen();
    t_stop();
    t_restart();
    t_inflight();
    wr(A_CLR, 32'h3);
    t_single();
    finish_run();
  end
endmodule